// File: doc/BRIEF.md
# Multiprocessor-mode serial transmitter

This block is an asynchronous serial transmitter for a line shared by several processors. Every character carries one extra bit after its data bits. The receiving nodes use that bit to tell an address character from a data character. Software, or a DMA engine that answers the block's empty request, feeds characters through a one-deep holding register. A shift register sends each held character out bit by bit. Bit timing comes from a programmable divider that produces one enable pulse per bit period.

Three flags give the handshake. The empty flag says when the holding register may be written. The done flag says when the line has gone quiet with nothing left to send. The multiprocessor bit flag holds the value that will go out with the pending character. When transmission is disabled, the pin falls back to a port path that software can drive directly. Software sends a break by driving that path low and then disabling the transmitter.

Top module: `mpser_tx`

## Requirements
- R1: After reset, `txd` is 1, `empty` is 1, `tend` is 1, `mpb_flag` is 0 and `txi` is 0 (with `tx_en` low).
- R2: A `cpu_wr` pulse stores `cpu_data` only while `empty` reads 1. While `empty` is 0, a `cpu_wr` pulse has no effect on the character that is sent.
- R3: A `st_wr` pulse while `empty` is 1 copies `st_mpb` into `mpb_flag`. If `st_clr` is also 1, the same pulse clears `empty` to 0 and hands the stored character over. A `st_wr` pulse while `empty` is 0 changes nothing.
- R4: A frame on `txd` is one start bit (0), then the `DATA_W` data bits with the least significant first, then the multiprocessor bit, then one stop bit (1). Each bit lasts `div_val`+1 clock cycles. The line idles at 1.
- R5: A handed-over character moves into the shift register on the first bit tick after `empty` is cleared, provided the line is free. At that same edge, `empty` returns to 1.
- R6: `txi` is 1 exactly when `empty` is 1 and `tx_en` is 1.
- R7: A `dma_wr` pulse while `empty` is 1 stores `dma_data` and clears `empty` in the same edge, with no status write. A `dma_wr` pulse while `empty` is 0 is ignored. When `dma_wr` and `cpu_wr` arrive together, the DMA value wins.
- R8: `tend` is 1 exactly when no frame is in progress and `empty` is 1.
- R9: When a character is pending as a frame's stop bit ends, the next start bit follows with no idle bit in between.
- R10: Dropping `tx_en` aborts the frame in progress at the next edge and returns `txd` to 1. A character pending in the holding register stays pending and is sent after `tx_en` rises again.
- R11: While `tx_en` is 0 and `port_dir` is 1, `txd` follows `port_dat`, which allows a break to be held low. While `tx_en` is 1, the port path is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable; selects the serial function for the pin |
| div_val | input | DIV_W | Bit period minus one, in clock cycles |
| cpu_wr | input | 1 | Software write strobe for the holding register |
| cpu_data | input | DATA_W | Software write data |
| st_wr | input | 1 | Software status write strobe |
| st_mpb | input | 1 | Multiprocessor bit value for the pending character |
| st_clr | input | 1 | Clear the empty flag with this status write |
| dma_wr | input | 1 | DMA write strobe; also clears the empty flag |
| dma_data | input | DATA_W | DMA write data |
| port_dir | input | 1 | Port direction: 1 drives the pin from `port_dat` while disabled |
| port_dat | input | 1 | Port output level |
| txd | output | 1 | Serial line |
| txi | output | 1 | Transmit-empty request |
| empty | output | 1 | Holding register empty flag |
| tend | output | 1 | Transmission done flag |
| mpb_flag | output | 1 | Multiprocessor bit for the pending character |

## Verification
Characters are sent with alternating and asymmetric data patterns and with both multiprocessor bit values. A mid-bit decoder on the line shows whether bit order, the bit period and the position of the extra bit are right. A software-fed stream that keeps a character pending is compared with a DMA-fed stream; this shows whether the automatic clear and the back-to-back frame chaining behave the same on both paths. Writes made while the holding register is full, an abort in the middle of a frame, a held-low break and a divider value of zero each check one corner in isolation. A behavioural reference model, compared on every clock, catches any flag or line level that goes out of step by even one cycle.

// File: rtl/mpser_pkg.sv
package mpser_pkg;

   typedef enum logic [1:0] {
      WSRC_NONE = 2'd0,
      WSRC_CPU  = 2'd1,
      WSRC_DMA  = 2'd2
   } wsrc_e;

   typedef struct packed {
      logic empty;
      logic done;
      logic mpb;
   } tx_stat_t;

   localparam int unsigned MIN_DATA_W = 5;
   localparam int unsigned MAX_DATA_W = 9;

endpackage

// File: rtl/mpser_baud.sv
module mpser_baud #(
   parameter int unsigned DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_val,
   output logic             tick
);

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("mpser_baud: DIV_W must be at least 1");
      end
   endgenerate

   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q >= div_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4: with a period above one clock, two ticks never come back to back
   a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div_val != '0 && $stable(div_val)) |=> !tick);

endmodule

// File: rtl/mpser_tdr.sv
module mpser_tdr
   import mpser_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              dma_wr,
   input  logic [DATA_W-1:0] dma_data,
   input  logic              st_wr,
   input  logic              st_mpb,
   input  logic              st_clr,
   input  logic              load,
   output logic              empty,
   output logic [DATA_W-1:0] data_q,
   output logic              mpb_q
);

   wsrc_e src;

   always_comb begin
      src = WSRC_NONE;
      if (empty) begin
         if (dma_wr) begin
            src = WSRC_DMA;
         end else if (cpu_wr) begin
            src = WSRC_CPU;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty  <= 1'b1;
         data_q <= '0;
         mpb_q  <= 1'b0;
      end else if (load) begin
         empty <= 1'b1;
      end else begin
         case (src)
            WSRC_DMA: begin
               data_q <= dma_data;
               empty  <= 1'b0;
            end
            WSRC_CPU: data_q <= cpu_data;
            default: ;
         endcase
         if (empty && st_wr) begin
            mpb_q <= st_mpb;
            if (st_clr) begin
               empty <= 1'b0;
            end
         end
      end
   end

   // R5: a move to the shifter frees the holding register at once
   a_r5_load_sets_empty: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> empty);
   // R7: a DMA write into an empty holding register clears the flag
   a_r7_dma_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_wr && empty) |=> !empty);
   // R2: nothing overwrites a pending character
   a_r2_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
      (!empty && !load) |=> $stable(data_q));

endmodule

// File: rtl/mpser_shift.sv
module mpser_shift #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] data,
   input  logic              mpb,
   output logic              bit_out,
   output logic              busy,
   output logic              free
);

   localparam int unsigned FRAME_W = DATA_W + 3;
   localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] sr_q;
   logic [CNT_W-1:0]   left_q;

   assign busy    = (left_q != '0);
   assign free    = (left_q <= CNT_W'(1));
   assign bit_out = busy ? sr_q[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q   <= '1;
         left_q <= '0;
      end else if (!run) begin
         sr_q   <= '1;
         left_q <= '0;
      end else if (load) begin
         sr_q   <= {1'b1, mpb, data, 1'b0};
         left_q <= CNT_W'(FRAME_W);
      end else if (tick && busy) begin
         sr_q   <= {1'b1, sr_q[FRAME_W-1:1]};
         left_q <= left_q - 1'b1;
      end
   end

   // R4: every frame begins with a low start bit
   a_r4_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (bit_out == 1'b0));
   // R10: disabling stops any frame at the next edge
   a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !busy);

endmodule

// File: rtl/mpser_pin.sv
module mpser_pin #(
   parameter bit OUT_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_en,
   input  logic shift_bit,
   input  logic port_dir,
   input  logic port_dat,
   output logic txd
);

   logic pin_d;

   always_comb begin
      if (tx_en) begin
         pin_d = shift_bit;
      end else if (port_dir) begin
         pin_d = port_dat;
      end else begin
         pin_d = 1'b1;
      end
   end

   generate
      if (OUT_REG) begin : g_flop
         logic pin_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pin_q <= 1'b1;
            end else begin
               pin_q <= pin_d;
            end
         end
         assign txd = pin_q;
      end else begin : g_direct
         assign txd = pin_d;
      end
   endgenerate

endmodule

// File: rtl/mpser_tx.sv
module mpser_tx
   import mpser_pkg::*;
#(
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned DIV_W   = 16,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en,
   input  logic [DIV_W-1:0]  div_val,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_data,
   input  logic              st_wr,
   input  logic              st_mpb,
   input  logic              st_clr,
   input  logic              dma_wr,
   input  logic [DATA_W-1:0] dma_data,
   input  logic              port_dir,
   input  logic              port_dat,
   output logic              txd,
   output logic              txi,
   output logic              empty,
   output logic              tend,
   output logic              mpb_flag
);

   generate
      if (DATA_W < MIN_DATA_W || DATA_W > MAX_DATA_W) begin : g_bad_width
         $error("mpser_tx: DATA_W out of range");
      end
   endgenerate

   logic              tick;
   logic              load;
   logic              sh_busy;
   logic              sh_free;
   logic              sh_bit;
   logic [DATA_W-1:0] hold_data;
   tx_stat_t          stat;

   mpser_baud #(.DIV_W(DIV_W)) u_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (tx_en),
      .div_val (div_val),
      .tick    (tick)
   );

   mpser_tdr #(.DATA_W(DATA_W)) u_tdr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cpu_wr   (cpu_wr),
      .cpu_data (cpu_data),
      .dma_wr   (dma_wr),
      .dma_data (dma_data),
      .st_wr    (st_wr),
      .st_mpb   (st_mpb),
      .st_clr   (st_clr),
      .load     (load),
      .empty    (stat.empty),
      .data_q   (hold_data),
      .mpb_q    (stat.mpb)
   );

   assign load = tick && sh_free && !stat.empty;

   mpser_shift #(.DATA_W(DATA_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (tx_en),
      .tick    (tick),
      .load    (load),
      .data    (hold_data),
      .mpb     (stat.mpb),
      .bit_out (sh_bit),
      .busy    (sh_busy),
      .free    (sh_free)
   );

   mpser_pin #(.OUT_REG(OUT_REG)) u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_en     (tx_en),
      .shift_bit (sh_bit),
      .port_dir  (port_dir),
      .port_dat  (port_dat),
      .txd       (txd)
   );

   assign stat.done = stat.empty && !sh_busy;

   assign empty    = stat.empty;
   assign tend     = stat.done;
   assign mpb_flag = stat.mpb;
   assign txi      = stat.empty && tx_en;

   // R8: a done line is an idle line
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      tend |-> (sh_bit == 1'b1));
   // R9: a pending character at the end of a stop bit starts at once
   a_r9_chain: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && tick && sh_busy && sh_free && !stat.empty) |=> sh_busy);

endmodule

// File: tb/mpser_tx_bench.sv
module mpser_tx_bench;

   localparam int DW = 8;
   localparam int VW = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_en = 1'b0;
   logic [VW-1:0] div_val = 16'd3;
   logic cpu_wr = 1'b0;
   logic [DW-1:0] cpu_data = '0;
   logic st_wr = 1'b0, st_mpb = 1'b0, st_clr = 1'b0;
   logic dma_wr = 1'b0;
   logic [DW-1:0] dma_data = '0;
   logic port_dir = 1'b0, port_dat = 1'b1;
   logic txd, txi, empty, tend, mpb_flag;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   mpser_tx u_mpser_tx (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .div_val(div_val),
      .cpu_wr(cpu_wr), .cpu_data(cpu_data), .st_wr(st_wr), .st_mpb(st_mpb),
      .st_clr(st_clr), .dma_wr(dma_wr), .dma_data(dma_data),
      .port_dir(port_dir), .port_dat(port_dat), .txd(txd), .txi(txi),
      .empty(empty), .tend(tend), .mpb_flag(mpb_flag)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int  m_cnt = 0;
   bit  m_empty = 1'b1;
   bit  m_mpb = 1'b0;
   int  m_data = 0;
   bit  m_q[$];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_empty = 1'b1; m_mpb = 1'b0; m_data = 0; m_q.delete();
      end else begin
         bit tk, ld, e0;
         tk = tx_en && (m_cnt >= int'(div_val));
         m_cnt = (!tx_en || tk) ? 0 : m_cnt + 1;
         ld = tx_en && tk && (m_q.size() <= 1) && !m_empty;
         e0 = m_empty;
         if (!tx_en) m_q.delete();
         else begin
            if (tk && m_q.size() > 0) void'(m_q.pop_front());
            if (ld) begin
               m_q.push_back(1'b0);
               for (int i = 0; i < DW; i++) m_q.push_back(m_data[i]);
               m_q.push_back(m_mpb);
               m_q.push_back(1'b1);
            end
         end
         if (ld) m_empty = 1'b1;
         else begin
            if (e0 && dma_wr) begin m_data = int'(dma_data); m_empty = 1'b0; end
            else if (e0 && cpu_wr) m_data = int'(cpu_data);
            if (e0 && st_wr) begin
               m_mpb = st_mpb;
               if (st_clr) m_empty = 1'b0;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         bit et, ee;
         et = tx_en ? ((m_q.size() > 0) ? m_q[0] : 1'b1) : (port_dir ? port_dat : 1'b1);
         ee = (m_q.size() == 0) && m_empty;
         chk(txd == et, "R4 txd vs model", txd, et);
         chk(empty == m_empty, "R5 empty vs model", empty, m_empty);
         chk(tend == ee, "R8 tend vs model", tend, ee);
         chk(txi == (m_empty && tx_en), "R6 txi vs model", txi, m_empty && tx_en);
         chk(mpb_flag == m_mpb, "R3 mpb vs model", mpb_flag, m_mpb);
      end
   end

   // ---------------- mid-bit line decoder ----------------
   int rx_got[$];
   int exp_q[$];
   bit d_on = 1'b0;
   int d_ph = 0, d_bit = 0;
   bit [DW+2:0] d_sh;

   always @(negedge clk) begin
      if (!rst_n || !tx_en) d_on = 1'b0;
      else if (!d_on) begin
         if (txd == 1'b0) begin d_on = 1'b1; d_ph = 0; d_bit = 0; end
      end
      if (d_on && rst_n && tx_en) begin
         int p;
         p = int'(div_val) + 1;
         if (d_ph == p / 2) begin
            d_sh[d_bit] = txd;
            if (d_bit == DW + 2) begin
               d_on = 1'b0;
               chk(d_sh[0] == 1'b0 && d_sh[DW+2] == 1'b1, "R4 start/stop", int'(d_sh), 0);
               rx_got.push_back(int'(d_sh[DW+1:1]));
            end
         end
         if (d_on) begin
            if (d_ph == p - 1) begin d_ph = 0; d_bit++; end else d_ph++;
         end
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wait_empty();
      while (!empty) step(1);
   endtask

   task automatic sw_send(input int d, input bit mb);
      wait_empty();
      cpu_wr = 1'b1; cpu_data = DW'(d);
      st_wr = 1'b1; st_mpb = mb; st_clr = 1'b1;
      exp_q.push_back((int'(mb) << DW) | d);
      step(1);
      cpu_wr = 1'b0; st_wr = 1'b0; st_clr = 1'b0;
   endtask

   task automatic wait_done();
      step(1);
      while (!tend) step(1);
      step(int'(div_val) + 3);
   endtask

   task automatic cmp_rx(input string tag);
      chk(rx_got.size() == exp_q.size(), tag, rx_got.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < rx_got.size(); i++)
         chk(rx_got[i] == exp_q[i], tag, rx_got[i], exp_q[i]);
      rx_got.delete();
      exp_q.delete();
   endtask

   task automatic run_all();
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1 reset values
      chk(txd == 1'b1 && empty && tend && !mpb_flag && !txi, "R1 reset state",
          {txd, empty, tend, mpb_flag, txi}, 5'b11100);

      tx_en = 1'b1;
      step(1);
      chk(txi == 1'b1, "R6 txi when enabled and empty", txi, 1);
      sw_send(8'hA5, 1'b1);
      chk(mpb_flag == 1'b1, "R3 mpb flag set", mpb_flag, 1);
      wait_done();
      sw_send(8'h01, 1'b0);
      wait_done();
      cmp_rx("R4 single frames");

      // R2 and R9: pending character, write while full ignored
      sw_send(8'h3C, 1'b1);
      step(8);
      sw_send(8'hF0, 1'b0);
      chk(empty == 1'b0, "R3 clear hands over", empty, 0);
      cpu_wr = 1'b1; cpu_data = 8'h77; st_wr = 1'b1; st_mpb = 1'b1;
      step(1);
      cpu_wr = 1'b0; st_wr = 1'b0;
      chk(mpb_flag == 1'b0, "R3 status write ignored while full", mpb_flag, 0);
      wait_done();
      cmp_rx("R2 R9 back-to-back with ignored write");

      // R7: DMA stream driven by txi
      for (int k = 0; k < 4; k++) begin
         while (!txi) step(1);
         dma_wr = 1'b1; dma_data = DW'(8'h11 * (k + 2));
         cpu_wr = (k == 1); cpu_data = 8'hEE;
         exp_q.push_back((int'(mpb_flag) << DW) | (8'h11 * (k + 2)));
         step(1);
         dma_wr = 1'b0; cpu_wr = 1'b0;
         chk(empty == 1'b0, "R7 dma clears empty", empty, 0);
         dma_wr = 1'b1; dma_data = 8'h99;
         step(1);
         dma_wr = 1'b0;
      end
      wait_done();
      cmp_rx("R7 dma stream");

      // R10: abort mid-frame, pending kept
      sw_send(8'hC3, 1'b0);
      step(12);
      sw_send(8'h5A, 1'b1);
      exp_q.delete();
      exp_q.push_back((1 << DW) | 8'h5A);
      tx_en = 1'b0;
      step(1);
      chk(txd == 1'b1, "R10 line idle after abort", txd, 1);
      chk(empty == 1'b0 && tend == 1'b0, "R10 pending kept", {empty, tend}, 0);
      rx_got.delete();
      step(10);
      tx_en = 1'b1;
      wait_done();
      cmp_rx("R10 pending sent after enable");

      // R11: break through port path
      port_dir = 1'b1; port_dat = 1'b0;
      step(2);
      chk(txd == 1'b1, "R11 port ignored while enabled", txd, 1);
      tx_en = 1'b0;
      step(1);
      chk(txd == 1'b0, "R11 break held low", txd, 0);
      step(20);
      chk(txd == 1'b0, "R11 break still low", txd, 0);
      port_dat = 1'b1;
      step(1);
      chk(txd == 1'b1, "R11 port high", txd, 1);
      port_dir = 1'b0;

      // R4 with a one-clock bit period
      div_val = '0;
      tx_en = 1'b1;
      step(1);
      sw_send(8'h96, 1'b0);
      sw_send(8'h69, 1'b1);
      wait_done();
      cmp_rx("R4 R9 one-clock bits");
      step(5);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            bad++;
            total++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule